// File: doc/BRIEF.md
# Timer Match Unit with Watchdog Reset

This block keeps one free-running 32-bit up-counter and compares it against four 32-bit match values. The counter advances by one on every clock cycle in which the `tick_i` strobe is high, so the tick rate is set outside the block. When the count steps onto a match value and that channel's interrupt enable is set, the channel latches a status flag that drives its own level interrupt line. Software lowers a line by writing a one to its status bit.

Channel 3 doubles as a one-shot watchdog. A small state machine, `tmu_wdog`, holds three named states: `WD_IDLE` (watchdog off), `WD_ARMED` (watchdog on) and `WD_FIRE` (a one-cycle reset request). Transitions: `WD_IDLE -> WD_ARMED` on a write of 1 to the arm bit; `WD_ARMED -> WD_IDLE` on a write of 0 to it; `WD_ARMED -> WD_FIRE` when channel 3 matches (this wins over a same-cycle write); `WD_FIRE -> WD_ARMED` on a same-cycle write of 1; otherwise `WD_FIRE -> WD_IDLE`. The arm bit reads 1 only in `WD_ARMED`, so firing disarms the watchdog.

Registers are 32-bit words reached through a simple single-cycle register port. Reads are combinational on the address; writes take effect at the clock edge where `bus_sel_i` and `bus_wr_i` are both high.

Top module: `tmu_top`

## Requirements
- R1: After reset every register reads zero, `irq_o` is 0 and `rst_req_o` is 0.
- R2: The count rises by exactly one at each clock edge where `tick_i` is high (and no counter write occurs), holds otherwise, and wraps from 0xFFFFFFFF to 0.
- R3: A write to the counter word (offset 0x10) loads the written value even if `tick_i` is high in that cycle; counting resumes from the loaded value.
- R4: Match words for channels 0..3 sit at offsets 0x00, 0x04, 0x08, 0x0C. When a tick moves the count onto channel n's match value and bit n of the enable word (offset 0x1C) is 1, bit n of the status word (offset 0x14) and `irq_o[n]` read 1 from the following cycle; a match onto 0 via wrap counts.
- R5: A match on a channel whose enable bit is 0 leaves its status bit and interrupt at 0; loading the counter directly with a match value is not a match.
- R6: `irq_o[n]` stays high until its status bit is cleared, even if the count moves on or the enable bit is later cleared.
- R7: A write to the status word clears each bit written as 1 and leaves bits written as 0 unchanged; a new match in the same cycle as a clear leaves the bit set.
- R8: When bit 0 of the watchdog word (offset 0x18) is 1 and a tick moves the count onto channel 3's match value, `rst_req_o` is high for exactly one cycle (the cycle after that edge) whatever enable bit 3 holds, and the watchdog bit then reads 0.
- R9: With the watchdog bit at 0, whether never set or written back to 0, a channel 3 match produces no reset request.
- R10: Reads of unassigned offsets (0x20 and above, or any address with low two bits non-zero) return 0, and writes to them change no register.
- R11: Unused upper bits of the status, enable and watchdog words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable strobe, one count per high cycle |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe, qualified by select |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| irq_o | output | 4 | Per-channel level interrupts |
| rst_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
Matches are provoked by counting up to a match value one tick at a time, by wrapping from the top of the range onto a zero match value, and by loading the counter straight to a match value; the first two must raise status while the third must not, which separates a tick-driven comparison from a plain equality test. Channels are tried with enable set and clear, and status clears are applied with mixed one/zero masks and coinciding with a fresh match, distinguishing per-bit clearing from whole-word clearing and set-over-clear priority. The watchdog is exercised armed, never armed and armed then disarmed, with enable bit 3 off, so the reset request is shown to depend only on the arm bit and to fire just once.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;

    // Word index of each register group, relative to the channel count
    function automatic int unsigned cnt_word(input int unsigned n_ch);
        return n_ch;
    endfunction

    function automatic int unsigned stat_word(input int unsigned n_ch);
        return n_ch + 1;
    endfunction

    function automatic int unsigned wd_word(input int unsigned n_ch);
        return n_ch + 2;
    endfunction

    function automatic int unsigned ie_word(input int unsigned n_ch);
        return n_ch + 3;
    endfunction

endpackage

// File: rtl/tmu_counter.sv
module tmu_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          ld_i,
    input  logic [DW-1:0] ld_val_i,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] cnt_nxt_o,
    output logic          adv_o
);

    logic [DW-1:0] cnt_q;

    assign cnt_nxt_o = cnt_q + {{(DW-1){1'b0}}, 1'b1};
    assign adv_o     = tick_i & ~ld_i;
    assign cnt_o     = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end else if (tick_i) begin
            cnt_q <= cnt_nxt_o;
        end
    end

endmodule

// File: rtl/tmu_match_chan.sv
module tmu_match_chan #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic          adv_i,
    input  logic [DW-1:0] cnt_nxt_i,
    output logic [DW-1:0] match_o,
    output logic          hit_o,
    output logic          set_o,
    output logic          status_o
);

    logic [DW-1:0] match_q;
    logic          status_q;

    // A hit is a tick that steps the count onto the match value
    assign hit_o = adv_i & (cnt_nxt_i == match_q);
    assign set_o = hit_o & en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '0;
        end else if (wr_i) begin
            match_q <= wdata_i;
        end
    end

    // A fresh event outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (set_o) begin
            status_q <= 1'b1;
        end else if (clr_i) begin
            status_q <= 1'b0;
        end
    end

    assign match_o  = match_q;
    assign status_o = status_q;

endmodule

// File: rtl/tmu_wdog.sv
module tmu_wdog
    import tmu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic arm_bit_i,
    input  logic hit_i,
    output logic armed_o,
    output logic rst_req_o
);

    wd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (wr_i && arm_bit_i) state_d = WD_ARMED;
            end
            WD_ARMED: begin
                if (hit_i)                  state_d = WD_FIRE;
                else if (wr_i && !arm_bit_i) state_d = WD_IDLE;
            end
            WD_FIRE: begin
                if (wr_i && arm_bit_i) state_d = WD_ARMED;
                else                   state_d = WD_IDLE;
            end
            default: state_d = WD_IDLE;
        endcase
    end

    always_comb begin
        armed_o   = 1'b0;
        rst_req_o = 1'b0;
        unique case (state_q)
            WD_IDLE:  ;
            WD_ARMED: armed_o   = 1'b1;
            WD_FIRE:  rst_req_o = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/tmu_regif.sv
module tmu_regif
    import tmu_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int DW     = 32,
    parameter int ADDR_W = 8
) (
    input  logic                     sel_i,
    input  logic                     wr_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [N_CH-1:0][DW-1:0]  match_i,
    input  logic [DW-1:0]            cnt_i,
    input  logic [N_CH-1:0]          status_i,
    input  logic                     armed_i,
    input  logic [N_CH-1:0]          ie_i,
    output logic [N_CH-1:0]          wr_match_o,
    output logic                     wr_cnt_o,
    output logic                     wr_stat_o,
    output logic                     wr_wd_o,
    output logic                     wr_ie_o,
    output logic [DW-1:0]            rdata_o
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] IDX_CNT  = IDX_W'(cnt_word(N_CH));
    localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(stat_word(N_CH));
    localparam logic [IDX_W-1:0] IDX_WD   = IDX_W'(wd_word(N_CH));
    localparam logic [IDX_W-1:0] IDX_IE   = IDX_W'(ie_word(N_CH));

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             we;

    assign idx     = addr_i[ADDR_W-1:2];
    assign aligned = (addr_i[1:0] == 2'b00);
    assign we      = sel_i & wr_i & aligned;

    for (genvar g = 0; g < N_CH; g++) begin : g_wsel
        assign wr_match_o[g] = we & (idx == IDX_W'(g));
    end

    assign wr_cnt_o  = we & (idx == IDX_CNT);
    assign wr_stat_o = we & (idx == IDX_STAT);
    assign wr_wd_o   = we & (idx == IDX_WD);
    assign wr_ie_o   = we & (idx == IDX_IE);

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            for (int i = 0; i < N_CH; i++) begin
                if (idx == IDX_W'(i)) rdata_o = match_i[i];
            end
            if (idx == IDX_CNT)  rdata_o = cnt_i;
            if (idx == IDX_STAT) rdata_o = {{(DW-N_CH){1'b0}}, status_i};
            if (idx == IDX_WD)   rdata_o = {{(DW-1){1'b0}}, armed_i};
            if (idx == IDX_IE)   rdata_o = {{(DW-N_CH){1'b0}}, ie_i};
        end
    end

endmodule

// File: rtl/tmu_top.sv
module tmu_top
    import tmu_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int DW     = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic [N_CH-1:0]   irq_o,
    output logic              rst_req_o
);

    localparam int WD_CH = N_CH - 1;

    logic [N_CH-1:0][DW-1:0] match_vals;
    logic [N_CH-1:0]         wr_match;
    logic [N_CH-1:0]         hit_vec;
    logic [N_CH-1:0]         set_vec;
    logic [N_CH-1:0]         stat_vec;
    logic [N_CH-1:0]         ie_q;
    logic [DW-1:0]           cnt_q;
    logic [DW-1:0]           cnt_nxt;
    logic                    cnt_adv;
    logic                    cnt_wr;
    logic                    stat_wr;
    logic                    wd_wr;
    logic                    ie_wr;
    logic                    wd_armed;

    tmu_regif #(
        .N_CH   (N_CH),
        .DW     (DW),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .sel_i      (bus_sel_i),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .match_i    (match_vals),
        .cnt_i      (cnt_q),
        .status_i   (stat_vec),
        .armed_i    (wd_armed),
        .ie_i       (ie_q),
        .wr_match_o (wr_match),
        .wr_cnt_o   (cnt_wr),
        .wr_stat_o  (stat_wr),
        .wr_wd_o    (wd_wr),
        .wr_ie_o    (ie_wr),
        .rdata_o    (bus_rdata_o)
    );

    tmu_counter #(
        .DW (DW)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .ld_i      (cnt_wr),
        .ld_val_i  (bus_wdata_i),
        .cnt_o     (cnt_q),
        .cnt_nxt_o (cnt_nxt),
        .adv_o     (cnt_adv)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        tmu_match_chan #(
            .DW (DW)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr_match[g]),
            .wdata_i   (bus_wdata_i),
            .clr_i     (stat_wr & bus_wdata_i[g]),
            .en_i      (ie_q[g]),
            .adv_i     (cnt_adv),
            .cnt_nxt_i (cnt_nxt),
            .match_o   (match_vals[g]),
            .hit_o     (hit_vec[g]),
            .set_o     (set_vec[g]),
            .status_o  (stat_vec[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= '0;
        end else if (ie_wr) begin
            ie_q <= bus_wdata_i[N_CH-1:0];
        end
    end

    tmu_wdog u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wd_wr),
        .arm_bit_i (bus_wdata_i[0]),
        .hit_i     (hit_vec[WD_CH]),
        .armed_o   (wd_armed),
        .rst_req_o (rst_req_o)
    );

    assign irq_o = stat_vec;

endmodule

// File: rtl/tmu_chk.sv
module tmu_chk #(
    parameter int N_CH = 4,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick_i,
    input logic            cnt_wr,
    input logic            stat_wr,
    input logic [DW-1:0]   wdata,
    input logic [DW-1:0]   cnt_q,
    input logic [N_CH-1:0] ie_q,
    input logic [N_CH-1:0] set_vec,
    input logic [N_CH-1:0] irq_o,
    input logic            wd_armed,
    input logic            rst_req_o
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr) |=> $stable(cnt_q)); // R2

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(wdata))); // R3

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~$past(irq_o) & ~$past(ie_q)) == '0)); // R5

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> (($past(irq_o) & ~irq_o) == '0)); // R6

    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((irq_o & $past(wdata[N_CH-1:0]) & ~$past(set_vec)) == '0)); // R7

    AST_WD_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o); // R8

    AST_WD_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !wd_armed); // R8

    AST_WD_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(wd_armed)); // R9

endmodule

bind tmu_top tmu_chk #(
    .N_CH (N_CH),
    .DW   (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .cnt_wr    (cnt_wr),
    .stat_wr   (stat_wr),
    .wdata     (bus_wdata_i),
    .cnt_q     (cnt_q),
    .ie_q      (ie_q),
    .set_vec   (set_vec),
    .irq_o     (irq_o),
    .wd_armed  (wd_armed),
    .rst_req_o (rst_req_o)
);

// File: tb/tb_tmu_top.sv
module tb_tmu_top;

    localparam logic [7:0] A_M0 = 8'h00, A_M1 = 8'h04, A_M2 = 8'h08, A_M3 = 8'h0C;
    localparam logic [7:0] A_CNT = 8'h10, A_ST = 8'h14, A_WD = 8'h18, A_IE = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        bus_sel_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [3:0]  irq_o;
    logic        rst_req_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    tmu_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .bus_sel_i   (bus_sel_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o),
        .rst_req_o   (rst_req_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr_i = a;
        #1;
        d = bus_rdata_o;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(8'(a * 4), v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 irq", {28'h0, irq_o}, 32'h0);
        chk("R1 rst_req", {31'h0, rst_req_o}, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(A_CNT, 32'd100);
        tick(3);
        rd(A_CNT, v); chk("R2 step", v, 32'd103);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); chk("R2 hold", v, 32'd103);
        wr(A_CNT, 32'hFFFF_FFFE);
        tick(2);
        rd(A_CNT, v); chk("R2 wrap", v, 32'h0);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = A_CNT; bus_wdata_i = 32'd50; tick_i = 1'b1;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0; tick_i = 1'b0;
        rd(A_CNT, v); chk("R3 load beats tick", v, 32'd50);
        tick(1);
        rd(A_CNT, v); chk("R3 resume", v, 32'd51);
    endtask

    task automatic t_match();
        logic [31:0] v;
        wr(A_IE, 32'h1);
        wr(A_M0, 32'd5);
        wr(A_CNT, 32'd3);
        tick(1);
        rd(A_ST, v); chk("R4 no early status", v, 32'h0);
        tick(1);
        rd(A_ST, v); chk("R4 status set", v, 32'h1);
        chk("R4 irq", {28'h0, irq_o}, 32'h1);
        tick(2);
        chk("R6 irq held", {28'h0, irq_o}, 32'h1);
        wr(A_IE, 32'h0);
        chk("R6 irq held after disable", {28'h0, irq_o}, 32'h1);
        wr(A_ST, 32'hE);
        rd(A_ST, v); chk("R7 zero bits keep", v, 32'h1);
        wr(A_ST, 32'h1);
        rd(A_ST, v); chk("R7 clear", v, 32'h0);
        chk("R7 irq low", {28'h0, irq_o}, 32'h0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        wr(A_IE, 32'h1);
        wr(A_M2, 32'd20);
        wr(A_CNT, 32'd19);
        tick(1);
        rd(A_ST, v); chk("R5 disabled channel", v, 32'h0);
        chk("R5 disabled irq", {28'h0, irq_o}, 32'h0);
        wr(A_CNT, 32'd5);
        rd(A_ST, v); chk("R5 load is no match", v, 32'h0);
        rd(A_IE, v); chk("R11 enable word", v, 32'h1);
    endtask

    task automatic t_wrap_match();
        logic [31:0] v;
        wr(A_IE, 32'h2);
        wr(A_M1, 32'h0);
        wr(A_CNT, 32'hFFFF_FFFF);
        tick(1);
        rd(A_ST, v); chk("R4 wrap match", v, 32'h2);
        chk("R4 wrap irq", {28'h0, irq_o}, 32'h2);
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, v); chk("R7 clear all", v, 32'h0);
    endtask

    task automatic t_clear_race();
        logic [31:0] v;
        wr(A_IE, 32'h1);
        wr(A_CNT, 32'd4);
        tick(1);
        rd(A_ST, v); chk("R4 set before race", v, 32'h1);
        wr(A_CNT, 32'd4);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = A_ST; bus_wdata_i = 32'h1; tick_i = 1'b1;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0; tick_i = 1'b0;
        rd(A_ST, v); chk("R7 set beats clear", v, 32'h1);
        wr(A_ST, 32'h1);
        rd(A_ST, v); chk("R7 clear after race", v, 32'h0);
    endtask

    task automatic t_wdog();
        logic [31:0] v;
        wr(A_IE, 32'h0);
        wr(A_M3, 32'd10);
        wr(A_WD, 32'hFFFF_FFFF);
        rd(A_WD, v); chk("R11 watchdog word", v, 32'h1);
        wr(A_CNT, 32'd9);
        chk("R8 no early request", {31'h0, rst_req_o}, 32'h0);
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        chk("R8 request", {31'h0, rst_req_o}, 32'h1);
        rd(A_WD, v); chk("R8 disarmed", v, 32'h0);
        @(negedge clk);
        chk("R8 single cycle", {31'h0, rst_req_o}, 32'h0);
        rd(A_ST, v); chk("R8 status untouched", v, 32'h0);
        wr(A_CNT, 32'd9);
        tick(1);
        chk("R9 no second request", {31'h0, rst_req_o}, 32'h0);
        wr(A_WD, 32'h1);
        wr(A_WD, 32'h0);
        wr(A_CNT, 32'd9);
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        chk("R9 disarmed by write", {31'h0, rst_req_o}, 32'h0);
    endtask

    task automatic t_undef();
        logic [31:0] v;
        wr(A_IE, 32'h5);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R10 read 0x20", v, 32'h0);
        rd(8'hFC, v); chk("R10 read 0xFC", v, 32'h0);
        wr(8'h01, 32'hABCD);
        wr(8'h1D, 32'hF);
        rd(8'h01, v); chk("R10 read unaligned", v, 32'h0);
        rd(A_M0, v); chk("R10 match0 intact", v, 32'd5);
        rd(A_IE, v); chk("R10 enable intact", v, 32'h5);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_match();
        t_disabled();
        t_wrap_match();
        t_clear_race();
        t_wdog();
        t_undef();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule